// File: doc/BRIEF.md
# Controlled PUF Key Sequencer

This block is the only path between software and an on-chip physical unclonable function (PUF). Software never addresses the PUF directly. It hands the sequencer a request, and the sequencer drives the one-way hash engine, the PUF and the error-correction engine in turn. The result depends on the mode chosen with the request.

In enrolment mode (`req_boot` = 1), the supplied value is a pre-challenge. The sequencer first runs it through the hash engine, and only the hash output is ever applied to the PUF. The raw response then leaves the block for one cycle on `boot_resp`. This is the only way a raw response can leave.

In key mode (`req_boot` = 0), the supplied value is a public challenge. It is applied to the PUF as is. The noisy response goes to the corrector together with the public syndrome carried by the request. The corrected secret is XORed with the request's access code, and the result is held in a volatile key register. That register feeds only the on-chip decryption port `dec_key`.

Only one key lives in the block at a time. Accepting any request wipes the previous key. The zeroize input also wipes it at any time.

The sequencer has four states:
- IDLE, which accepts requests.
- HASH, which waits for the hash engine.
- PUF, which waits for the PUF.
- ECC, which waits for the corrector.

The transitions are:
- IDLE→HASH when an enrolment request is accepted.
- IDLE→PUF when a key request is accepted.
- HASH→PUF on `hash_done`.
- PUF→IDLE on `puf_done` in enrolment mode.
- PUF→ECC on `puf_done` in key mode.
- ECC→IDLE on `ecc_done`.

Top module: `puf_key_seq`

## Requirements
- R1: `req_ready` is high exactly in IDLE. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `busy` is high from the cycle after acceptance until the cycle in which the result pulse appears, and it is low in that cycle.
- R2: In enrolment mode, `hash_req` is held high with `hash_in` equal to the pre-challenge until `hash_done`. The PUF then receives `hash_out` on `puf_chal`, never the pre-challenge itself.
- R3: An enrolment sequence ends with a one-cycle `boot_valid` pulse carrying the PUF response on `boot_resp`. `boot_resp` is all zero in every cycle where `boot_valid` is low.
- R4: In key mode, no hash request is made, and `puf_chal` carries the supplied challenge unchanged. `hash_in` and `puf_chal` are zero whenever their request line is low.
- R5: In key mode, the corrector receives the raw PUF response on `ecc_resp` and the request's syndrome on `ecc_synd`, both while `ecc_req` is high. The syndrome is RESP_W−KEY_W bits wide, which is 148 bits for a 255-bit response and a 107-bit secret. Both ports are zero otherwise.
- R6: On a successful correction, `dec_key` becomes `ecc_secret` XOR access code. `key_live` goes high, and `key_valid` pulses for one cycle. The key then holds until it is cleared.
- R7: Accepting any request clears `dec_key` to zero and `key_live` to low at that edge. Both stay cleared for the whole sequence.
- R8: If `ecc_fail` is high with `ecc_done`, the key stays cleared, `key_err` pulses for one cycle, and `key_valid` does not pulse.
- R9: A request presented while the block is busy is not accepted and not remembered. After the running sequence ends, no new sequence starts unless a request is presented again.
- R10: `zeroize` clears `dec_key` and `key_live` at the next edge in any state. It wins over a key load on the same edge, and that load then gives no `key_valid`.
- R11: After reset the block is in IDLE. `req_ready` is high and every other output is zero.
- R12: A key-mode sequence never pulses `boot_valid`, so neither the response nor the key appears on `boot_resp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| zeroize | input | 1 | Wipe the key register |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (IDLE) |
| req_boot | input | 1 | 1 = enrolment, 0 = key generation |
| req_chal | input | CHAL_W | Pre-challenge or public challenge |
| req_acode | input | KEY_W | Access code |
| req_synd | input | RESP_W-KEY_W | Public syndrome |
| busy | output | 1 | Sequence in progress |
| hash_req | output | 1 | Hash engine request (level) |
| hash_in | output | CHAL_W | Hash input |
| hash_done | input | 1 | Hash result valid |
| hash_out | input | CHAL_W | Hash result |
| puf_req | output | 1 | PUF request (level) |
| puf_chal | output | CHAL_W | Challenge applied to PUF |
| puf_done | input | 1 | PUF response valid |
| puf_resp | input | RESP_W | PUF response |
| ecc_req | output | 1 | Corrector request (level) |
| ecc_resp | output | RESP_W | Noisy response to corrector |
| ecc_synd | output | RESP_W-KEY_W | Syndrome to corrector |
| ecc_done | input | 1 | Correction finished |
| ecc_fail | input | 1 | Uncorrectable response |
| ecc_secret | input | KEY_W | Corrected secret |
| boot_valid | output | 1 | Enrolment response pulse |
| boot_resp | output | RESP_W | Enrolment response, zero otherwise |
| key_valid | output | 1 | Key loaded pulse |
| key_err | output | 1 | Key generation failed pulse |
| key_live | output | 1 | A key is held |
| dec_key | output | KEY_W | Key to on-chip decryption port |

## Verification
The bound checker watches every cycle for these properties:
- `boot_resp` stays zero outside a `boot_valid` pulse, and the result pulses never overlap.
- The engine requests are mutually exclusive, and acceptance raises `busy`.
- Acceptance and `zeroize` clear the key, a held key stays stable, and a correction failure yields `key_err` without a key.

Only the bench's scenarios can show that values are right. They confirm that the challenge applied in enrolment is the hash of the pre-challenge, that the key equals the corrected secret XOR the access code, and that a request offered while busy is dropped rather than queued. They also exercise `zeroize` landing exactly on the load edge and during a correction wait.

// File: rtl/pks_pkg.sv
package pks_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HASH = 2'd1,
        ST_PUF  = 2'd2,
        ST_ECC  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/pks_fsm.sv
module pks_fsm
    import pks_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_boot,
    input  logic hash_done,
    input  logic puf_done,
    input  logic ecc_done,
    input  logic ecc_fail,
    output logic req_ready,
    output logic busy,
    output logic hash_req,
    output logic puf_req,
    output logic ecc_req,
    output logic accept,
    output logic hash_take,
    output logic puf_take,
    output logic boot_fin,
    output logic key_load,
    output logic key_fail
);
    seq_state_e state_q, state_d;
    logic       boot_q;

    // state register (with the mode latched at acceptance)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            boot_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) boot_q <= req_boot;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = req_boot ? ST_HASH : ST_PUF;
            ST_HASH: if (hash_done) state_d = ST_PUF;
            ST_PUF:  if (puf_done)  state_d = boot_q ? ST_IDLE : ST_ECC;
            ST_ECC:  if (ecc_done)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        busy      = 1'b1;
        hash_req  = 1'b0;
        puf_req   = 1'b0;
        ecc_req   = 1'b0;
        accept    = 1'b0;
        hash_take = 1'b0;
        puf_take  = 1'b0;
        boot_fin  = 1'b0;
        key_load  = 1'b0;
        key_fail  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                busy      = 1'b0;
                accept    = req_valid;
            end
            ST_HASH: begin
                hash_req  = 1'b1;
                hash_take = hash_done;
            end
            ST_PUF: begin
                puf_req  = 1'b1;
                puf_take = puf_done && !boot_q;
                boot_fin = puf_done && boot_q;
            end
            ST_ECC: begin
                ecc_req  = 1'b1;
                key_load = ecc_done && !ecc_fail;
                key_fail = ecc_done && ecc_fail;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/pks_datapath.sv
module pks_datapath #(
    parameter int CHAL_W = 64,
    parameter int RESP_W = 255,
    parameter int KEY_W  = 107
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    hash_take,
    input  logic                    puf_take,
    input  logic                    boot_fin,
    input  logic                    hash_req,
    input  logic                    puf_req,
    input  logic                    ecc_req,
    input  logic [CHAL_W-1:0]       req_chal,
    input  logic [KEY_W-1:0]        req_acode,
    input  logic [RESP_W-KEY_W-1:0] req_synd,
    input  logic [CHAL_W-1:0]       hash_out,
    input  logic [RESP_W-1:0]       puf_resp,
    output logic [CHAL_W-1:0]       hash_in,
    output logic [CHAL_W-1:0]       puf_chal,
    output logic [RESP_W-1:0]       ecc_resp,
    output logic [RESP_W-KEY_W-1:0] ecc_synd,
    output logic [KEY_W-1:0]        acode_o,
    output logic                    boot_valid,
    output logic [RESP_W-1:0]       boot_resp
);
    localparam int SYND_W = RESP_W - KEY_W;

    logic [CHAL_W-1:0] chal_q;
    logic [RESP_W-1:0] resp_q;
    logic [SYND_W-1:0] synd_q;
    logic [KEY_W-1:0]  acode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chal_q     <= '0;
            resp_q     <= '0;
            synd_q     <= '0;
            acode_q    <= '0;
            boot_valid <= 1'b0;
            boot_resp  <= '0;
        end else begin
            if (accept) begin
                chal_q  <= req_chal;
                synd_q  <= req_synd;
                acode_q <= req_acode;
                resp_q  <= '0;
            end
            // the hashed value replaces the pre-challenge
            if (hash_take) chal_q <= hash_out;
            if (puf_take)  resp_q <= puf_resp;
            boot_valid <= boot_fin;
            boot_resp  <= boot_fin ? puf_resp : '0;
        end
    end

    assign hash_in  = hash_req ? chal_q : '0;
    assign puf_chal = puf_req  ? chal_q : '0;
    assign ecc_resp = ecc_req  ? resp_q : '0;
    assign ecc_synd = ecc_req  ? synd_q : '0;
    assign acode_o  = acode_q;
endmodule

// File: rtl/pks_keyreg.sv
module pks_keyreg #(
    parameter int KEY_W = 107
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             zeroize,
    input  logic             load,
    input  logic             fail,
    input  logic [KEY_W-1:0] secret,
    input  logic [KEY_W-1:0] acode,
    output logic [KEY_W-1:0] key_q,
    output logic             live_q,
    output logic             key_valid,
    output logic             key_err
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q     <= '0;
            live_q    <= 1'b0;
            key_valid <= 1'b0;
            key_err   <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            key_err   <= fail;
            if (zeroize || clear || fail) begin
                key_q  <= '0;
                live_q <= 1'b0;
            end else if (load) begin
                key_q     <= secret ^ acode;
                live_q    <= 1'b1;
                key_valid <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/puf_key_seq.sv
module puf_key_seq #(
    parameter int CHAL_W = 64,
    parameter int RESP_W = 255,
    parameter int KEY_W  = 107
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    zeroize,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_boot,
    input  logic [CHAL_W-1:0]       req_chal,
    input  logic [KEY_W-1:0]        req_acode,
    input  logic [RESP_W-KEY_W-1:0] req_synd,
    output logic                    busy,
    output logic                    hash_req,
    output logic [CHAL_W-1:0]       hash_in,
    input  logic                    hash_done,
    input  logic [CHAL_W-1:0]       hash_out,
    output logic                    puf_req,
    output logic [CHAL_W-1:0]       puf_chal,
    input  logic                    puf_done,
    input  logic [RESP_W-1:0]       puf_resp,
    output logic                    ecc_req,
    output logic [RESP_W-1:0]       ecc_resp,
    output logic [RESP_W-KEY_W-1:0] ecc_synd,
    input  logic                    ecc_done,
    input  logic                    ecc_fail,
    input  logic [KEY_W-1:0]        ecc_secret,
    output logic                    boot_valid,
    output logic [RESP_W-1:0]       boot_resp,
    output logic                    key_valid,
    output logic                    key_err,
    output logic                    key_live,
    output logic [KEY_W-1:0]        dec_key
);
    logic             accept, hash_take, puf_take, boot_fin, key_load, key_fail;
    logic [KEY_W-1:0] acode;

    pks_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_boot(req_boot),
        .hash_done(hash_done), .puf_done(puf_done),
        .ecc_done(ecc_done), .ecc_fail(ecc_fail),
        .req_ready(req_ready), .busy(busy),
        .hash_req(hash_req), .puf_req(puf_req), .ecc_req(ecc_req),
        .accept(accept), .hash_take(hash_take), .puf_take(puf_take),
        .boot_fin(boot_fin), .key_load(key_load), .key_fail(key_fail)
    );

    pks_datapath #(.CHAL_W(CHAL_W), .RESP_W(RESP_W), .KEY_W(KEY_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .accept(accept), .hash_take(hash_take), .puf_take(puf_take),
        .boot_fin(boot_fin),
        .hash_req(hash_req), .puf_req(puf_req), .ecc_req(ecc_req),
        .req_chal(req_chal), .req_acode(req_acode), .req_synd(req_synd),
        .hash_out(hash_out), .puf_resp(puf_resp),
        .hash_in(hash_in), .puf_chal(puf_chal),
        .ecc_resp(ecc_resp), .ecc_synd(ecc_synd), .acode_o(acode),
        .boot_valid(boot_valid), .boot_resp(boot_resp)
    );

    pks_keyreg #(.KEY_W(KEY_W)) u_key (
        .clk(clk), .rst_n(rst_n),
        .clear(accept), .zeroize(zeroize),
        .load(key_load), .fail(key_fail),
        .secret(ecc_secret), .acode(acode),
        .key_q(dec_key), .live_q(key_live),
        .key_valid(key_valid), .key_err(key_err)
    );
endmodule

// File: rtl/pks_checker.sv
module pks_checker #(
    parameter int RESP_W = 255,
    parameter int KEY_W  = 107
) (
    input logic              clk,
    input logic              rst_n,
    input logic              zeroize,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              hash_req,
    input logic              puf_req,
    input logic              ecc_req,
    input logic              ecc_done,
    input logic              ecc_fail,
    input logic              boot_valid,
    input logic [RESP_W-1:0] boot_resp,
    input logic              key_valid,
    input logic              key_err,
    input logic              key_live,
    input logic [KEY_W-1:0]  dec_key
);
    p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy && !req_ready);

    p_engine_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hash_req, puf_req, ecc_req}));

    p_resp_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_valid |-> boot_resp == '0);

    p_boot_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        boot_valid |=> !boot_valid);

    p_key_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_live && !zeroize && !(req_valid && req_ready) |=> $stable(dec_key) && key_live);

    p_valid_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_live);

    p_accept_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> dec_key == '0 && !key_live);

    p_dead_key_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !key_live |-> dec_key == '0);

    p_fail_no_key_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_req && ecc_done && ecc_fail |=> key_err && !key_valid && !key_live);

    p_zeroize_r10: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> dec_key == '0 && !key_live && !key_valid);

    p_one_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({boot_valid, key_valid, key_err}) <= 1);
endmodule

bind puf_key_seq pks_checker #(.RESP_W(RESP_W), .KEY_W(KEY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .zeroize(zeroize),
    .req_valid(req_valid), .req_ready(req_ready), .busy(busy),
    .hash_req(hash_req), .puf_req(puf_req), .ecc_req(ecc_req),
    .ecc_done(ecc_done), .ecc_fail(ecc_fail),
    .boot_valid(boot_valid), .boot_resp(boot_resp),
    .key_valid(key_valid), .key_err(key_err),
    .key_live(key_live), .dec_key(dec_key)
);

// File: tb/tb_puf_key_seq.sv
module tb_puf_key_seq;
    localparam int CW = 64;
    localparam int RW = 255;
    localparam int KW = 107;
    localparam int SW = RW - KW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic          zeroize = 1'b0, req_valid = 1'b0, req_boot = 1'b0;
    logic [CW-1:0] req_chal = '0;
    logic [KW-1:0] req_acode = '0;
    logic [SW-1:0] req_synd = '0;
    logic          req_ready, busy, hash_req, puf_req, ecc_req;
    logic [CW-1:0] hash_in, puf_chal;
    logic          hash_done = 1'b0, puf_done = 1'b0, ecc_done = 1'b0, ecc_fail = 1'b0;
    logic [CW-1:0] hash_out = '0;
    logic [RW-1:0] puf_resp = '0, ecc_resp, boot_resp;
    logic [SW-1:0] ecc_synd;
    logic [KW-1:0] ecc_secret = '0, dec_key;
    logic          boot_valid, key_valid, key_err, key_live;

    puf_key_seq #(.CHAL_W(CW), .RESP_W(RW), .KEY_W(KW)) dut (.*);

    // deterministic stand-ins for the engines
    function automatic logic [CW-1:0] hash_fn(input logic [CW-1:0] x);
        return {x[CW-2:0], x[CW-1]} ^ (x >> 5) ^ 64'h9E37_79B9_7F4A_7C15;
    endfunction

    function automatic logic [RW-1:0] puf_fn(input logic [CW-1:0] c);
        logic [RW-1:0] r;
        for (int i = 0; i < RW; i++)
            r[i] = c[i % CW] ^ c[(i * 7 + 3) % CW] ^ ((i % 3) == 0);
        return r;
    endfunction

    // stand-in corrector: secret = low bits of response XOR low bits of syndrome;
    // syndrome top bit set = uncorrectable (bench convention)
    function automatic logic [KW-1:0] key_fn(input logic [CW-1:0] c,
                                             input logic [SW-1:0] s,
                                             input logic [KW-1:0] a);
        logic [RW-1:0] r;
        r = puf_fn(c);
        return r[KW-1:0] ^ s[KW-1:0] ^ a;
    endfunction

    int hcnt = 0, pcnt = 0, ecnt = 0;
    always @(posedge clk) begin
        hash_done <= 1'b0;
        puf_done  <= 1'b0;
        ecc_done  <= 1'b0;
        if (hash_req && !hash_done) begin
            if (hcnt == 2) begin
                hash_done <= 1'b1; hash_out <= hash_fn(hash_in); hcnt <= 0;
            end else hcnt <= hcnt + 1;
        end
        if (puf_req && !puf_done) begin
            if (pcnt == 1) begin
                puf_done <= 1'b1; puf_resp <= puf_fn(puf_chal); pcnt <= 0;
            end else pcnt <= pcnt + 1;
        end
        if (ecc_req && !ecc_done) begin
            if (ecnt == 3) begin
                ecc_done   <= 1'b1;
                ecc_fail   <= ecc_synd[SW-1];
                ecc_secret <= ecc_resp[KW-1:0] ^ ecc_synd[KW-1:0];
                ecnt <= 0;
            end else ecnt <= ecnt + 1;
        end
    end

    // behavioural reference model
    int            m_ph = 0;
    bit            m_boot = 0, m_bv = 0, m_kv = 0, m_err = 0, m_live = 0;
    logic [CW-1:0] m_pre = '0, m_echal = '0;
    logic [SW-1:0] m_synd = '0;
    logic [KW-1:0] m_acode = '0, m_key = '0;
    logic [RW-1:0] m_bresp = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_bv <= 0; m_kv <= 0; m_err <= 0; m_live <= 0;
            m_key <= '0; m_bresp <= '0;
        end else begin
            m_bv <= 0; m_kv <= 0; m_err <= 0; m_bresp <= '0;
            case (m_ph)
                0: if (req_valid) begin
                    m_ph    <= req_boot ? 1 : 2;
                    m_boot  <= req_boot;
                    m_pre   <= req_chal;
                    m_echal <= req_boot ? hash_fn(req_chal) : req_chal;
                    m_synd  <= req_synd;
                    m_acode <= req_acode;
                    m_key   <= '0;
                    m_live  <= 0;
                end
                1: if (hash_done) m_ph <= 2;
                2: if (puf_done) begin
                    if (m_boot) begin
                        m_bv <= 1; m_bresp <= puf_fn(m_echal); m_ph <= 0;
                    end else m_ph <= 3;
                end
                3: if (ecc_done) begin
                    m_ph <= 0;
                    if (m_synd[SW-1]) m_err <= 1;
                    else if (!zeroize) begin
                        m_key <= key_fn(m_echal, m_synd, m_acode);
                        m_live <= 1; m_kv <= 1;
                    end
                end
                default: m_ph <= 0;
            endcase
            if (zeroize) begin m_key <= '0; m_live <= 0; end
        end
    end

    int  n_chk = 0, n_fail = 0;
    bit  running = 0, finished = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // compare with the model on every cycle
    always @(negedge clk) begin
        if (running) begin
            chk(req_ready == (m_ph == 0) && busy == (m_ph != 0), "R1 ready/busy",
                {req_ready, busy}, {m_ph == 0, m_ph != 0});
            chk(hash_req == (m_ph == 1) && hash_in == ((m_ph == 1) ? m_pre : '0),
                "R2 hash request", hash_in, (m_ph == 1) ? m_pre : '0);
            chk(puf_req == (m_ph == 2) && puf_chal == ((m_ph == 2) ? m_echal : '0),
                "R2 R4 puf challenge", puf_chal, (m_ph == 2) ? m_echal : '0);
            chk(ecc_req == (m_ph == 3) && ecc_synd == ((m_ph == 3) ? m_synd : '0)
                && ecc_resp == ((m_ph == 3) ? puf_fn(m_echal) : '0),
                "R5 corrector inputs", ecc_resp, (m_ph == 3) ? puf_fn(m_echal) : '0);
            chk(boot_valid == m_bv && boot_resp == m_bresp, "R3 R12 boot output",
                boot_resp, m_bresp);
            chk(key_valid == m_kv && key_live == m_live && dec_key == m_key,
                "R6 R7 R10 key register", {key_valid, key_live, dec_key},
                {m_kv, m_live, m_key});
            chk(key_err == m_err, "R8 key error", key_err, m_err);
        end
    end

    task automatic send(input bit boot, input logic [CW-1:0] c,
                        input logic [KW-1:0] a, input logic [SW-1:0] s);
        @(negedge clk);
        req_boot = boot; req_chal = c; req_acode = a; req_synd = s; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    logic [RW-1:0] cap;
    logic [SW-1:0] s_ok = {1'b0, {(SW-1){1'b0}}} | {{(SW-64){1'b0}}, 64'h5A5A_0F0F_3C3C_1234};
    logic [SW-1:0] s_bad = {1'b1, {(SW-1){1'b0}}};

    initial begin
        // R11 reset state
        repeat (2) @(negedge clk);
        chk(req_ready && !busy && !hash_req && !puf_req && !ecc_req && !boot_valid
            && boot_resp == '0 && !key_valid && !key_err && !key_live && dec_key == '0,
            "R11 reset state", {req_ready, busy, key_live}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1;

        // R2 R3 enrolment, two pre-challenges
        for (int n = 0; n < 2; n++) begin
            logic [CW-1:0] pre;
            pre = (n == 0) ? 64'h0123_4567_89AB_CDEF : 64'hFFFF_0000_1234_8001;
            send(1'b1, pre, '0, '0);
            @(negedge clk);
            while (!boot_valid) @(negedge clk);
            cap = boot_resp;
            chk(cap == puf_fn(hash_fn(pre)), "R2 R3 response of hashed pre-challenge",
                cap, puf_fn(hash_fn(pre)));
            chk(cap != puf_fn(pre), "R2 pre-challenge not applied", cap, puf_fn(pre));
            wait_idle();
        end

        // R4 R5 R6 key generation
        send(1'b0, 64'hCAFE_F00D_0000_0042, 107'h1_2345_6789_ABCD_EF01_2345_6789, s_ok);
        wait_idle();
        chk(key_live && dec_key == key_fn(64'hCAFE_F00D_0000_0042, s_ok,
            107'h1_2345_6789_ABCD_EF01_2345_6789), "R6 key value", dec_key,
            key_fn(64'hCAFE_F00D_0000_0042, s_ok, 107'h1_2345_6789_ABCD_EF01_2345_6789));

        // R7 R9 second key replaces first; request while busy is dropped
        send(1'b0, 64'h0000_0000_0000_0007, 107'h7, s_ok);
        repeat (2) @(negedge clk);
        chk(busy && dec_key == '0 && !key_live, "R7 key cleared during sequence",
            dec_key, '0);
        req_boot = 1'b1; req_chal = 64'h1111; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        for (int i = 0; i < 6; i++) begin
            chk(!busy && !hash_req && !boot_valid, "R9 busy request not queued",
                {busy, hash_req}, 2'b00);
            @(negedge clk);
        end

        // R8 uncorrectable response
        send(1'b0, 64'hDEAD_BEEF_0000_0001, 107'h55, s_bad);
        @(negedge clk);
        while (!key_err) @(negedge clk);
        chk(!key_valid && !key_live && dec_key == '0, "R8 no key on failure",
            {key_valid, key_live}, 2'b00);
        wait_idle();

        // R10 zeroize at idle
        send(1'b0, 64'h0BAD_CAFE_0000_0003, 107'h99, s_ok);
        wait_idle();
        chk(key_live, "R6 key held", key_live, 1);
        zeroize = 1'b1;
        @(negedge clk);
        zeroize = 1'b0;
        chk(!key_live && dec_key == '0, "R10 zeroize at idle", dec_key, '0);

        // R10 zeroize on the load edge
        send(1'b0, 64'h0000_1234_5678_0009, 107'hABC, s_ok);
        @(negedge clk);
        while (!ecc_done) @(negedge clk);
        zeroize = 1'b1;
        @(negedge clk);
        zeroize = 1'b0;
        chk(!key_valid && !key_live && dec_key == '0, "R10 zeroize wins over load",
            {key_valid, key_live}, 2'b00);
        wait_idle();

        // R10 zeroize during correction wait, then R12 key mode gives no boot pulse
        send(1'b0, 64'h7777_0000_0000_0011, 107'h3, s_ok);
        @(negedge clk);
        while (!ecc_req) @(negedge clk);
        zeroize = 1'b1;
        @(negedge clk);
        zeroize = 1'b0;
        wait_idle();
        chk(key_live && dec_key == key_fn(64'h7777_0000_0000_0011, s_ok, 107'h3),
            "R10 R12 key after zeroize mid-sequence", dec_key,
            key_fn(64'h7777_0000_0000_0011, s_ok, 107'h3));

        running = 0;
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=running exp=done");
            summary();
            $finish;
        end
    end
endmodule